// File: doc/BRIEF.md
# Dual-CPU Doorbell Interrupt Unit

This peripheral lets two processors ring each other's doorbell. Each processor owns a 4-bit status word that any bus master can raise through a write-one-to-set register and lower through a write-one-to-clear register. Each processor also owns an interrupt line that stays high for as long as any bit of its status word is set. A typical exchange runs like this: the sender sets a bit in the receiver's word. The receiver takes the interrupt, reads its status, and clears the bits it has handled.

The block is an APB-style slave with a 4 KB window. Every transfer finishes in its access phase without wait states. A fixed block of byte-wide identification registers sits at the top of the window. An illegal access leaves all state unchanged, returns zero data and raises the slave error flag. Illegal accesses are: a read of a write-only register, a write to a read-only register, and any misaligned or unmapped address.

Top module: `mhu_doorbell`

## Requirements
- R1: After synchronous active-low reset, both status words are zero, both interrupt outputs are low, and the status registers read zero. A reset asserted mid-operation clears any pending bits.
- R2: A write to a CPU's set register (CPU0 at 0x004, CPU1 at 0x014) ORs bits [3:0] of the write data into that CPU's status word. Data bits [31:4] are ignored.
- R3: A write to a CPU's clear register (CPU0 at 0x008, CPU1 at 0x018) clears the status bits that are one in bits [3:0] of the write data. The other status bits are left unchanged.
- R4: Each CPU's interrupt output is high exactly when its status word is nonzero. It changes on the same clock edge that updates the status word.
- R5: The two CPUs' status words and interrupts are independent. A write addressed to one CPU never alters the other CPU's word.
- R6: The set and clear registers are write-only. Reading one returns zero with pslverr high.
- R7: The status registers (CPU0 at 0x000, CPU1 at 0x010) and the identification registers are read-only. Writing one changes no state and gives pslverr high.
- R8: Addresses that are misaligned (paddr[1:0] != 0) or unmapped read as zero with pslverr high. A write to such an address changes no state.
- R9: The identification registers, from 0xFD0 up to 0xFFC in steps of 4, read in turn as 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in the low byte, with zeros above. pslverr is low for these reads.
- R10: pready is always high. pslverr is low for every legal access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address inside the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high (no wait states) |
| pslverr | output | 1 | Illegal or unmapped access |
| irqCpu0 | output | 1 | Doorbell interrupt to CPU0 |
| irqCpu1 | output | 1 | Doorbell interrupt to CPU1 |

## Verification
The bench builds the block with the default 12-bit address and 32-bit data widths. With these widths every decoded offset can be reached. This includes the last word of the window at 0xFFC, a misaligned address inside a set register, and an address just past the second CPU's register group. The wide data bus lets the bench write ones above bit 3, which checks that only the four live status bits are taken.

// File: rtl/mhu_pkg.sv
package mhu_pkg;

  localparam int NUM_CPU    = 2;
  localparam int STAT_W     = 4;
  localparam int NUM_ID     = 12;
  localparam int ID_W       = $clog2(NUM_ID);
  localparam int CPU_IDX_W  = $clog2(NUM_CPU);
  localparam logic [11:0] ID_BASE = 12'hFD0;

  // register slot inside one CPU group, selected by paddr[3:2]
  localparam logic [1:0] SLOT_STAT = 2'd0;
  localparam logic [1:0] SLOT_SET  = 2'd1;
  localparam logic [1:0] SLOT_CLR  = 2'd2;

  typedef struct packed {
    logic [NUM_CPU-1:0] setStb;
    logic [NUM_CPU-1:0] clrStb;
    logic [NUM_CPU-1:0] statRd;
    logic               idRd;
    logic [ID_W-1:0]    idIdx;
    logic               slvErr;
  } ctrlStb_t;

  function automatic logic [7:0] idByte(input logic [ID_W-1:0] idx);
    case (idx)
      4'd0:    idByte = 8'h04;
      4'd4:    idByte = 8'h56;
      4'd5:    idByte = 8'hB8;
      4'd6:    idByte = 8'h0B;
      4'd8:    idByte = 8'h0D;
      4'd9:    idByte = 8'hF0;
      4'd10:   idByte = 8'h05;
      4'd11:   idByte = 8'hB1;
      default: idByte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mhu_ctrl.sv
module mhu_ctrl
  import mhu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output ctrlStb_t          stb
);

  localparam int GRP_LSB = 4 + CPU_IDX_W;

  logic                 access;
  logic                 aligned;
  logic                 idHit;
  logic                 grpHit;
  logic [CPU_IDX_W-1:0] cpuSel;
  logic [1:0]           slot;
  logic [ADDR_W-1:0]    idOff;

  assign access  = psel & penable;
  assign aligned = (paddr[1:0] == 2'b00);
  assign idHit   = aligned && (paddr >= ADDR_W'(ID_BASE));
  assign grpHit  = aligned && (paddr[ADDR_W-1:GRP_LSB] == '0);
  assign cpuSel  = paddr[GRP_LSB-1:4];
  assign slot    = paddr[3:2];
  assign idOff   = paddr - ADDR_W'(ID_BASE);

  always_comb begin
    stb = '0;
    if (access) begin
      if (idHit) begin
        if (pwrite) begin
          stb.slvErr = 1'b1;
        end else begin
          stb.idRd  = 1'b1;
          stb.idIdx = idOff[ID_W+1:2];
        end
      end else if (grpHit) begin
        unique case (slot)
          SLOT_STAT: begin
            if (pwrite) stb.slvErr = 1'b1;
            else        stb.statRd[cpuSel] = 1'b1;
          end
          SLOT_SET: begin
            if (pwrite) stb.setStb[cpuSel] = 1'b1;
            else        stb.slvErr = 1'b1;
          end
          SLOT_CLR: begin
            if (pwrite) stb.clrStb[cpuSel] = 1'b1;
            else        stb.slvErr = 1'b1;
          end
          default: stb.slvErr = 1'b1;
        endcase
      end else begin
        stb.slvErr = 1'b1;
      end
    end
  end

  AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setStb, stb.clrStb})) else $error("two updates at once"); // R5
  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    stb.slvErr |-> (stb.setStb == '0 && stb.clrStb == '0)) else $error("error access updated"); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(psel && penable) |-> (stb == '0)) else $error("strobe outside access"); // R10

endmodule

// File: rtl/mhu_dpath.sv
module mhu_dpath
  import mhu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [STAT_W-1:0]  wbits,
  output logic [DATA_W-1:0]  prdata,
  output logic [NUM_CPU-1:0] irq
);

  logic [NUM_CPU-1:0][STAT_W-1:0] status;
  logic [NUM_CPU-1:0][STAT_W-1:0] statusNext;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      if (stb.setStb[c])      statusNext[c] = status[c] | wbits;
      else if (stb.clrStb[c]) statusNext[c] = status[c] & ~wbits;
      else                    statusNext[c] = status[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      irq    <= '0;
    end else begin
      status <= statusNext;
      for (int c = 0; c < NUM_CPU; c++) irq[c] <= |statusNext[c];
    end
  end

  always_comb begin
    prdata = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (stb.statRd[c]) prdata = prdata | DATA_W'(status[c]);
    if (stb.idRd) prdata = prdata | DATA_W'(idByte(stb.idIdx));
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
    AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
      irq[g] == (status[g] != '0)) else $error("irq mismatch"); // R4
    AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rstN)
      stb.setStb[g] |=> ((status[g] & $past(status[g])) == $past(status[g]))) else $error("set lost bits"); // R2
    AST_CLR_ADDS_NONE: assert property (@(posedge clk) disable iff (!rstN)
      stb.clrStb[g] |=> ((status[g] & ~$past(status[g])) == '0)) else $error("clear added bits"); // R3
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.setStb[g] || stb.clrStb[g]) |=> $stable(status[g])) else $error("status moved"); // R7
  end

endmodule

// File: rtl/mhu_doorbell.sv
module mhu_doorbell
  import mhu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irqCpu0,
  output logic              irqCpu1
);

  ctrlStb_t           stb;
  logic [NUM_CPU-1:0] irq;
  logic               unusedHighBits;

  assign unusedHighBits = ^pwdata[DATA_W-1:STAT_W];

  mhu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .stb     (stb)
  );

  mhu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wbits  (pwdata[STAT_W-1:0]),
    .prdata (prdata),
    .irq    (irq)
  );

  assign pready  = 1'b1;
  assign pslverr = stb.slvErr;
  assign irqCpu0 = irq[0];
  assign irqCpu1 = irq[1];

endmodule

// File: tb/mhu_doorbell_tb.sv
module mhu_doorbell_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic        irqCpu0;
  logic        irqCpu1;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  mhu_doorbell u_dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irqCpu0(irqCpu0), .irqCpu1(irqCpu1)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] expRd;
    logic        expErr;
    logic [1:0]  expIrq;   // {cpu1, cpu0}
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 32'h0,        32'h0, 1'b0, 2'b00, 8'd1},  // R1
    '{1'b0, 12'h010, 32'h0,        32'h0, 1'b0, 2'b00, 8'd1},  // R1
    '{1'b1, 12'h004, 32'hFFFF_FFF5, 32'h0, 1'b0, 2'b01, 8'd2}, // R2 high bits dropped
    '{1'b0, 12'h000, 32'h0,        32'h5, 1'b0, 2'b01, 8'd2},  // R2
    '{1'b1, 12'h004, 32'h2,        32'h0, 1'b0, 2'b01, 8'd2},  // R2 OR in
    '{1'b0, 12'h000, 32'h0,        32'h7, 1'b0, 2'b01, 8'd2},  // R2
    '{1'b1, 12'h014, 32'h2,        32'h0, 1'b0, 2'b11, 8'd5},  // R5
    '{1'b0, 12'h010, 32'h0,        32'h2, 1'b0, 2'b11, 8'd5},  // R5
    '{1'b0, 12'h000, 32'h0,        32'h7, 1'b0, 2'b11, 8'd5},  // R5
    '{1'b1, 12'h008, 32'h3,        32'h0, 1'b0, 2'b11, 8'd3},  // R3
    '{1'b0, 12'h000, 32'h0,        32'h4, 1'b0, 2'b11, 8'd3},  // R3
    '{1'b0, 12'h004, 32'h0,        32'h0, 1'b1, 2'b11, 8'd6},  // R6
    '{1'b0, 12'h018, 32'h0,        32'h0, 1'b1, 2'b11, 8'd6},  // R6
    '{1'b1, 12'h000, 32'hF,        32'h0, 1'b1, 2'b11, 8'd7},  // R7
    '{1'b1, 12'hFE0, 32'hF,        32'h0, 1'b1, 2'b11, 8'd7},  // R7
    '{1'b0, 12'h000, 32'h0,        32'h4, 1'b0, 2'b11, 8'd7},  // R7 unchanged
    '{1'b1, 12'h00C, 32'hF,        32'h0, 1'b1, 2'b11, 8'd8},  // R8 unmapped slot
    '{1'b1, 12'h006, 32'hF,        32'h0, 1'b1, 2'b11, 8'd8},  // R8 misaligned
    '{1'b1, 12'h024, 32'hF,        32'h0, 1'b1, 2'b11, 8'd8},  // R8 past groups
    '{1'b0, 12'h800, 32'h0,        32'h0, 1'b1, 2'b11, 8'd8},  // R8
    '{1'b0, 12'h000, 32'h0,        32'h4, 1'b0, 2'b11, 8'd8},  // R8 unchanged
    '{1'b1, 12'h008, 32'hFFFF_FFF4, 32'h0, 1'b0, 2'b10, 8'd4}, // R4 cpu0 drops
    '{1'b1, 12'h018, 32'h2,        32'h0, 1'b0, 2'b00, 8'd4}   // R4 cpu1 drops
  };

  // one transfer; returns read data and error flag sampled in access phase
  task automatic apbXfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output logic err, output logic rdy);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; err = pslverr; rdy = pready;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  function automatic logic [7:0] expId(input int k);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                           8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic err, rdy;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state of the outputs
    nChecks++;
    if ({irqCpu1, irqCpu0} !== 2'b00) begin
      nFails++;
      $display("FAIL R1 reset irq actual=%b expected=00", {irqCpu1, irqCpu0});
    end

    for (int i = 0; i < NV; i++) begin
      apbXfer(VEC[i].wr, VEC[i].addr, VEC[i].wdata, rd, err, rdy);
      nChecks++;
      if ((!VEC[i].wr && rd !== VEC[i].expRd) || err !== VEC[i].expErr ||
          {irqCpu1, irqCpu0} !== VEC[i].expIrq || rdy !== 1'b1) begin
        nFails++;
        $display("FAIL R%0d vec %0d actual rd=%h err=%b irq=%b rdy=%b expected rd=%h err=%b irq=%b rdy=1",
                 VEC[i].req, i, rd, err, {irqCpu1, irqCpu0}, rdy,
                 VEC[i].expRd, VEC[i].expErr, VEC[i].expIrq);
      end
    end

    // R9 identification block, R10 no error on legal reads
    for (int k = 0; k < 12; k++) begin
      apbXfer(1'b0, 12'hFD0 + 12'(4 * k), 32'h0, rd, err, rdy);
      nChecks++;
      if (rd !== {24'h0, expId(k)} || err !== 1'b0 || rdy !== 1'b1) begin
        nFails++;
        $display("FAIL R9/R10 id %0d actual=%h err=%b expected=%h err=0", k, rd, err, expId(k));
      end
    end

    // R1 reset mid-operation clears pending bits
    apbXfer(1'b1, 12'h004, 32'h9, rd, err, rdy);
    apbXfer(1'b1, 12'h014, 32'h6, rd, err, rdy);
    nChecks++;
    if ({irqCpu1, irqCpu0} !== 2'b11) begin
      nFails++;
      $display("FAIL R4 both raised actual=%b expected=11", {irqCpu1, irqCpu0});
    end
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    nChecks++;
    if ({irqCpu1, irqCpu0} !== 2'b00) begin
      nFails++;
      $display("FAIL R1 irq after reset actual=%b expected=00", {irqCpu1, irqCpu0});
    end
    rstN = 1'b1;
    apbXfer(1'b0, 12'h000, 32'h0, rd, err, rdy);
    nChecks++;
    if (rd !== 32'h0) begin
      nFails++;
      $display("FAIL R1 cpu0 status after reset actual=%h expected=0", rd);
    end
    apbXfer(1'b0, 12'h010, 32'h0, rd, err, rdy);
    nChecks++;
    if (rd !== 32'h0) begin
      nFails++;
      $display("FAIL R1 cpu1 status after reset actual=%h expected=0", rd);
    end

    // R3 clearing bits that are not set leaves the rest
    apbXfer(1'b1, 12'h014, 32'hA, rd, err, rdy);
    apbXfer(1'b1, 12'h018, 32'h5, rd, err, rdy);
    apbXfer(1'b0, 12'h010, 32'h0, rd, err, rdy);
    nChecks++;
    if (rd !== 32'hA || {irqCpu1, irqCpu0} !== 2'b10) begin
      nFails++;
      $display("FAIL R3 clear of clear bits actual=%h irq=%b expected=a irq=10", rd, {irqCpu1, irqCpu0});
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule